// File: doc/BRIEF.md
# Two-Bit Opcode Fetch/Execute Sequencer

This block sequences a small two-register datapath (registers A and B, a function unit and a result bus) from a two-bit opcode. It has two phases that strictly alternate. In the fetch phase it raises the instruction-register load so the opcode on the low input bits is captured at the next clock edge. In the execute phase it decodes the held opcode and drives the source selects of A and B and the function select of the result bus. The datapath itself lies outside the block; only its select lines are produced here.

Every instruction takes two cycles: one to capture the opcode and one to carry it out. The input bits carry the opcode during fetch and, for the load-immediate instruction, the data word during execute. Whenever a phase does not call for an operation, both registers keep their value and the result bus shows A. The current phase and the held opcode are also driven out so the sequence can be followed.

Top module: `opctl_seq`

## Requirements
- R1: While reset is low and just after it is released, the phase output is 0 (fetch), the held opcode is 00, the load output is 1 and the selects are at their idle values.
- R2: After reset the phase output toggles on every clock edge, 0 meaning fetch and 1 meaning execute.
- R3: The opcode register takes the low two input bits at a clock edge only when the load output is 1 and otherwise keeps its value, so input changes during execute leave the held opcode unchanged.
- R4: In execute with opcode 00 (load immediate) the A select is 00 (input bus), the B select is 10 (hold B) and the function select is 000.
- R5: In execute with opcode 01 (copy A to B) the A select is 01 (hold A), the B select is 01 (take A) and the function select is 000.
- R6: In execute with opcode 10 (shift A right, zero fill) the A select is 11 (result bus), the B select is 10 and the function select is 111.
- R7: In execute with opcode 11 (add B to A) the A select is 11, the B select is 10 and the function select is 101.
- R8: In fetch the load output is 1 and the selects are idle (A select 01, B select 10, function select 000); in execute the load output is 0.
- R9: Reset is asynchronous and active low: pulling it low in the middle of execute returns the phase to fetch and clears the opcode before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 2 | Input bits: opcode in fetch, data in execute |
| ir_load | output | 1 | Opcode register load enable |
| sel_a | output | 2 | Source select of register A (00 input, 01 A, 10 B, 11 result) |
| sel_b | output | 2 | Source select of register B (same encoding) |
| sel_fn | output | 3 | Function select of the result bus (000 pass A, 101 add, 111 shift right) |
| phase | output | 1 | Current phase, 0 fetch, 1 execute |
| opcode | output | 2 | Held opcode |

## Verification
The assertions watch, on every cycle, that the phase alternates, that the opcode register captures exactly when loaded and is stable otherwise, that fetch always presents the idle selects with the load high, and that at most one of the two registers is written in any cycle. Which select values each opcode produces, that data bits seen during execute never leak into the held opcode, and that an asynchronous reset mid-instruction takes effect before the next edge can only be shown by the bench's scenarios, which compare against an opcode table written independently of the design.

// File: rtl/opctl_pkg.sv
`timescale 1ns/1ps
package opctl_pkg;
  localparam int OP_W  = 2;
  localparam int SEL_W = 2;
  localparam int FN_W  = 3;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;

  typedef logic [SEL_W-1:0] bus_sel_t;
  typedef logic [FN_W-1:0]  fn_sel_t;
  typedef logic [OP_W-1:0]  op_t;

  typedef struct packed {
    bus_sel_t a;
    bus_sel_t b;
    fn_sel_t  fn;
  } ctl_t;

  // register source encodings
  localparam bus_sel_t SRC_IN  = 2'b00;
  localparam bus_sel_t SRC_A   = 2'b01;
  localparam bus_sel_t SRC_B   = 2'b10;
  localparam bus_sel_t SRC_RES = 2'b11;

  // result bus function encodings
  localparam fn_sel_t FN_PASS_A = 3'b000;
  localparam fn_sel_t FN_ADD    = 3'b101;
  localparam fn_sel_t FN_SHR    = 3'b111;

  localparam ctl_t CTL_IDLE = '{a: SRC_A, b: SRC_B, fn: FN_PASS_A};

  // opcode meaning in the execute phase
  function automatic ctl_t op_decode(input op_t op);
    ctl_t c;
    c = CTL_IDLE;
    case (op)
      2'b00: c.a = SRC_IN;
      2'b01: c.b = SRC_A;
      2'b10: begin c.a = SRC_RES; c.fn = FN_SHR; end
      default: begin c.a = SRC_RES; c.fn = FN_ADD; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/opctl_ir.sv
`timescale 1ns/1ps
module opctl_ir #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // one hold-or-load cell per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt;
    assign nxt = load ? d[i] : q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/opctl_phase.sv
`timescale 1ns/1ps
module opctl_phase
  import opctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph
);
  phase_e ph_nxt;
  always_comb ph_nxt = (ph == PH_FETCH) ? PH_EXEC : PH_FETCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_FETCH;
    else        ph <= ph_nxt;
  end

  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph != $past(ph)));
endmodule

// File: rtl/opctl_decode.sv
`timescale 1ns/1ps
module opctl_decode
  import opctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e ph,
  input  op_t    op,
  output logic   ir_load,
  output ctl_t   ctl
);
  logic in_exec;
  assign in_exec = (ph == PH_EXEC);

  always_comb begin
    ir_load = !in_exec;
    ctl     = in_exec ? op_decode(op) : CTL_IDLE;
  end

  // only one of the two registers may be written in a cycle
  p_one_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((ctl.a != SRC_A) && (ctl.b != SRC_B)));
  p_exec_noload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_exec |-> !ir_load);
endmodule

// File: rtl/opctl_seq.sv
`timescale 1ns/1ps
module opctl_seq
  import opctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] din,
  output logic            ir_load,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic [FN_W-1:0] sel_fn,
  output logic            phase,
  output logic [OP_W-1:0] opcode
);
  phase_e ph;
  op_t    op_q;
  ctl_t   ctl;
  logic   load_w;

  opctl_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph)
  );

  opctl_ir #(.W(OP_W)) u_ir (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_w),
    .d     (din),
    .q     (op_q)
  );

  opctl_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (ph),
    .op      (op_q),
    .ir_load (load_w),
    .ctl     (ctl)
  );

  assign ir_load = load_w;
  assign sel_a   = ctl.a;
  assign sel_b   = ctl.b;
  assign sel_fn  = ctl.fn;
  assign phase   = ph;
  assign opcode  = op_q;

  // fetch never disturbs the datapath
  p_fetch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 1'b0) |-> (ir_load && sel_a == SRC_A && sel_b == SRC_B
                         && sel_fn == FN_PASS_A));
  // a fetch is followed by an execute of the captured opcode
  p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (phase == 1'b1 && opcode == $past(din)));
endmodule

// File: tb/opctl_seq_test.sv
`timescale 1ns/1ps
module opctl_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] din = 2'b00;
  logic       ir_load;
  logic [1:0] sel_a, sel_b, opcode;
  logic [2:0] sel_fn;
  logic       phase;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opctl_seq uut (
    .clk(clk), .rst_n(rst_n), .din(din), .ir_load(ir_load),
    .sel_a(sel_a), .sel_b(sel_b), .sel_fn(sel_fn),
    .phase(phase), .opcode(opcode)
  );

  // vector: {opcode, exec data, exp A sel, exp B sel, exp fn sel}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 2'b11, 2'b00, 2'b10, 3'b000},
    {2'b01, 2'b10, 2'b01, 2'b01, 3'b000},
    {2'b10, 2'b01, 2'b11, 2'b10, 3'b111},
    {2'b11, 2'b00, 2'b11, 2'b10, 3'b101},
    {2'b11, 2'b10, 2'b11, 2'b10, 3'b101},
    {2'b10, 2'b11, 2'b11, 2'b10, 3'b111},
    {2'b01, 2'b00, 2'b01, 2'b01, 3'b000},
    {2'b00, 2'b01, 2'b00, 2'b10, 3'b000}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "ir_load", ir_load, 1);
    chk(req, "sel_a", sel_a, 1);
    chk(req, "sel_b", sel_b, 2);
    chk(req, "sel_fn", sel_fn, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: state during reset
    @(negedge clk);
    @(negedge clk);
    chk("R1", "phase in reset", phase, 0);
    chk("R1", "opcode in reset", opcode, 0);
    chk_idle("R1");
    rst_n = 1'b1;
    #0.5;
    chk("R1", "phase after release", phase, 0);

    // table walk, each iteration starts at a fetch-phase negedge
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, dat, ea, eb;
      logic [2:0] ef;
      {op, dat, ea, eb, ef} = VEC[i];
      din = op;
      chk("R2", "phase fetch", phase, 0);
      chk_idle("R8");
      @(negedge clk);
      din = dat;
      chk("R2", "phase exec", phase, 1);
      chk("R3", "captured opcode", opcode, op);
      chk("R8", "ir_load exec", ir_load, 0);
      case (op)
        2'b00: begin chk("R4", "sel_a", sel_a, ea); chk("R4", "sel_b", sel_b, eb); chk("R4", "sel_fn", sel_fn, ef); end
        2'b01: begin chk("R5", "sel_a", sel_a, ea); chk("R5", "sel_b", sel_b, eb); chk("R5", "sel_fn", sel_fn, ef); end
        2'b10: begin chk("R6", "sel_a", sel_a, ea); chk("R6", "sel_b", sel_b, eb); chk("R6", "sel_fn", sel_fn, ef); end
        default: begin chk("R7", "sel_a", sel_a, ea); chk("R7", "sel_b", sel_b, eb); chk("R7", "sel_fn", sel_fn, ef); end
      endcase
      @(negedge clk);
      chk("R3", "opcode held over exec data", opcode, op);
    end

    // R9: asynchronous reset in the middle of execute
    din = 2'b11;
    @(negedge clk);
    chk("R9", "phase before reset", phase, 1);
    chk("R9", "opcode before reset", opcode, 3);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R9", "phase after async reset", phase, 0);
    chk("R9", "opcode after async reset", opcode, 0);
    chk("R9", "ir_load after async reset", ir_load, 1);
    @(negedge clk);
    rst_n = 1'b1;
    din = 2'b10;
    @(negedge clk);
    chk("R2", "exec after restart", phase, 1);
    chk("R6", "sel_fn after restart", sel_fn, 7);
    @(negedge clk);
    finish_run();
  end
endmodule